// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block holds a table of two-word buffer descriptors and runs two walkers over it, one for transmission and one for reception. A 32-bit register port lets the processor read and write every descriptor word and a transmit-count register. That register splits the one shared table in two. The lower entries form the transmit ring and the entries above them form the receive ring.

The transmit walker stops on its current descriptor until software marks it ready. It then offers the buffer address, length, pad and checksum flags to the MAC side. When the MAC signals completion, the walker writes the result flags back, gives the entry back to software and moves on. The receive walker offers its current descriptor's buffer while that entry is marked empty. When a frame arrives, the walker records the length and error flags in the descriptor. A frame that arrives with no empty descriptor is dropped and reported. Each ring wraps to its first entry after a descriptor whose wrap flag is set, or after the last entry of its region.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset, the transmit count reads 64 and every descriptor word reads 0. `tx_req`, `rx_buf_ok` and all event outputs are low.
- R2: Register map (byte addresses, word access):
  - 0x020 is the transmit count.
  - Descriptor i has its status word at 0x400+8i and its buffer address at 0x404+8i.
  - Any other address, and any address with bits 1:0 non-zero, reads 0.
- R3: A count write above 128 stores 128. Count 0 leaves the transmit walker idle. Count 128 leaves the receive walker idle, so every frame is dropped as busy.
- R4: `tx_req` is high while the count is non-zero and the current transmit descriptor has status bit 15 (ready) set. `tx_len` is status bits 31:16, `tx_pad` is bit 12, `tx_crc` is bit 11, and `tx_buf_addr` is the descriptor's address word.
- R5: A `tx_done` pulse writes back the current transmit status word as follows:
  - Bit 15 is cleared.
  - Bits 8:0 are replaced by `tx_result` (0 carrier lost, 1 defer, 2 late collision, 3 retry limit, 7:4 retries, 8 underrun).
  - Bits 31:16 and 14:9 are kept.
- R6: A `rx_frame` pulse on an empty receive descriptor (status bit 15 set) writes back the status word as follows:
  - Bits 31:16 take `rx_len` (which includes the CRC).
  - Bit 15 is cleared.
  - Bits 8:0 take `rx_err`.
  - Bits 14:9 are kept.
- R7: After a write-back, a walker moves to the next entry. It returns to the first entry of its ring (index 0 for transmit, index count for receive) if the finished descriptor had bit 13 (wrap) set or was the last entry of its region.
- R8: A walker stays on a descriptor that is not ready or not empty. A `rx_frame` pulse at such a moment leaves the table unchanged and pulses `ev_rx_busy` one cycle later.
- R9: One cycle after a write-back, and only when the descriptor's bit 14 (interrupt request) is set, the walker pulses its ok event if bits 8:0 written are all zero, or its error event otherwise.
- R10: Writing the count restarts the transmit walker at index 0 and the receive walker at index count.
- R11: A transmit completion and a receive frame in the same cycle both take effect. In the same cycle, a walker write-back overrides a processor write to the same status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_req | output | 1 | Transmit descriptor ready for the MAC |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit length |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append checksum |
| tx_done | input | 1 | Transmit completion pulse (only while `tx_req`) |
| tx_result | input | 9 | Transmit result flags |
| rx_buf_ok | output | 1 | An empty receive descriptor is available |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_frame | input | 1 | Frame received pulse |
| rx_len | input | 16 | Received length |
| rx_err | input | 9 | Receive error flags |
| ev_tx_ok | output | 1 | Transmit completed without error |
| ev_tx_err | output | 1 | Transmit completed with error |
| ev_rx_ok | output | 1 | Frame stored without error |
| ev_rx_err | output | 1 | Frame stored with error |
| ev_rx_busy | output | 1 | Frame dropped, no empty descriptor |

## Verification
A transmit completion and a receive frame can arrive in the same cycle. In that cycle the processor can also write the status word the transmit walker is about to write back. The bench provokes all three in one cycle. It then reads both descriptors back and expects both write-backs to be intact, with the processor value discarded. It also expects both ok events in the next cycle. A behavioural model of both rings runs beside the design and compares the request, buffer and event outputs every clock.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   localparam int FLAG_BIT = 15;   // ready (transmit) or empty (receive)
   localparam int IRQ_BIT  = 14;
   localparam int WRAP_BIT = 13;
   localparam int PAD_BIT  = 12;
   localparam int CRC_BIT  = 11;
   localparam int RES_W    = 9;    // result / error flags in bits 8:0
   localparam int LEN_LSB  = 16;

   typedef enum logic {WALK_TX = 1'b0, WALK_RX = 1'b1} walk_kind_e;
endpackage

// File: rtl/bdr_table.sv
module bdr_table #(
   parameter int NUM_BD = 128,
   localparam int IW    = $clog2(NUM_BD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [IW-1:0] cpu_idx,
   input  logic          cpu_word,
   input  logic [31:0]   cpu_wdata,
   output logic [31:0]   cpu_rdata,
   input  logic          hw_a_we,
   input  logic [IW-1:0] hw_a_idx,
   input  logic [31:0]   hw_a_stat,
   input  logic          hw_b_we,
   input  logic [IW-1:0] hw_b_idx,
   input  logic [31:0]   hw_b_stat,
   output logic [31:0]   a_stat,
   output logic [31:0]   a_addr,
   output logic [31:0]   b_stat,
   output logic [31:0]   b_addr
);
   logic [31:0] stat_q [NUM_BD];
   logic [31:0] addr_q [NUM_BD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BD; i++) begin
            stat_q[i] <= '0;
            addr_q[i] <= '0;
         end
      end else begin
         if (cpu_we && !cpu_word) stat_q[cpu_idx] <= cpu_wdata;
         if (cpu_we &&  cpu_word) addr_q[cpu_idx] <= cpu_wdata;
         // walker write-backs come last so they override the processor
         if (hw_a_we) stat_q[hw_a_idx] <= hw_a_stat;
         if (hw_b_we) stat_q[hw_b_idx] <= hw_b_stat;
      end
   end

   assign cpu_rdata = cpu_word ? addr_q[cpu_idx] : stat_q[cpu_idx];
   assign a_stat    = stat_q[hw_a_idx];
   assign a_addr    = addr_q[hw_a_idx];
   assign b_stat    = stat_q[hw_b_idx];
   assign b_addr    = addr_q[hw_b_idx];

   p_rings_disjoint_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_a_we && hw_b_we) |-> (hw_a_idx != hw_b_idx));
   p_tx_wb_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hw_a_we |=> !stat_q[$past(hw_a_idx)][bdr_pkg::FLAG_BIT]);
   p_rx_wb_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_b_we |=> !stat_q[$past(hw_b_idx)][bdr_pkg::FLAG_BIT]);
endmodule

// File: rtl/bdr_walker.sv
module bdr_walker
   import bdr_pkg::*;
#(
   parameter int         NUM_BD = 128,
   parameter walk_kind_e KIND   = WALK_TX,
   localparam int IW = $clog2(NUM_BD),
   localparam int CW = IW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [CW-1:0]    lo_i,
   input  logic [CW-1:0]    hi_i,
   input  logic             active_i,
   input  logic [31:0]      cur_stat_i,
   input  logic             evt_i,
   input  logic [RES_W-1:0] res_i,
   input  logic [15:0]      len_i,
   output logic [IW-1:0]    idx_o,
   output logic             avail_o,
   output logic             wr_en_o,
   output logic [31:0]      wr_stat_o,
   output logic             ok_o,
   output logic             err_o,
   output logic             busy_o
);
   logic [CW-1:0] off_q, abs_idx;
   logic          take, last;
   logic [15:0]   upper;

   assign abs_idx = lo_i + off_q;
   assign idx_o   = abs_idx[IW-1:0];
   assign avail_o = active_i && cur_stat_i[FLAG_BIT];
   assign take    = evt_i && avail_o;
   assign last    = cur_stat_i[WRAP_BIT] || (abs_idx == hi_i);
   assign upper   = (KIND == WALK_RX) ? len_i : cur_stat_i[31:LEN_LSB];

   assign wr_en_o   = take;
   assign wr_stat_o = {upper, 1'b0, cur_stat_i[FLAG_BIT-1:RES_W], res_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q <= '0;
         ok_o  <= 1'b0;
         err_o <= 1'b0;
      end else begin
         if (restart_i)  off_q <= '0;
         else if (take)  off_q <= last ? '0 : off_q + 1'b1;
         ok_o  <= take && cur_stat_i[IRQ_BIT] && (res_i == '0);
         err_o <= take && cur_stat_i[IRQ_BIT] && (res_i != '0);
      end
   end

   generate
      if (KIND == WALK_RX) begin : g_rx_busy
         logic busy_q;
         always_ff @(posedge clk) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= evt_i && !avail_o;
         end
         assign busy_o = busy_q;
      end else begin : g_tx_nobusy
         assign busy_o = 1'b0;
      end
   endgenerate

   p_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> (abs_idx <= hi_i));
   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!avail_o && !restart_i) |=> $stable(off_q));
   p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ok_o, err_o, busy_o}));
endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
   import bdr_pkg::*;
#(
   parameter int NUM_BD   = 128,
   parameter int AW       = 12,
   parameter int BD_BASE  = 32'h400,
   parameter int CNT_ADDR = 32'h020,
   parameter int CNT_RST  = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          tx_req,
   output logic [31:0]   tx_buf_addr,
   output logic [15:0]   tx_len,
   output logic          tx_pad,
   output logic          tx_crc,
   input  logic          tx_done,
   input  logic [8:0]    tx_result,
   output logic          rx_buf_ok,
   output logic [31:0]   rx_buf_addr,
   input  logic          rx_frame,
   input  logic [15:0]   rx_len,
   input  logic [8:0]    rx_err,
   output logic          ev_tx_ok,
   output logic          ev_tx_err,
   output logic          ev_rx_ok,
   output logic          ev_rx_err,
   output logic          ev_rx_busy
);
   localparam int IW      = $clog2(NUM_BD);
   localparam int CW      = IW + 1;
   localparam int TBL_END = BD_BASE + NUM_BD * 8;

   generate
      if (NUM_BD < 2 || (1 << IW) != NUM_BD) begin : g_bad_depth
         $error("NUM_BD must be a power of two of at least 2");
      end
      if (TBL_END > (1 << AW) || (BD_BASE % 8) != 0) begin : g_bad_base
         $error("descriptor table must be 8-byte aligned and fit the address space");
      end
      if (CNT_RST > NUM_BD || CNT_ADDR >= BD_BASE) begin : g_bad_cnt
         $error("count reset value or count address out of range");
      end
   endgenerate

   int            a_int, tbl_off;
   logic          aligned, hit_cnt, hit_tbl, cnt_we;
   logic [CW-1:0] count_q, count_d;
   logic [IW-1:0] cpu_idx, tx_idx, rx_idx;
   logic [31:0]   cpu_rdata, tx_stat, tx_addr, rx_stat, rx_addr;
   logic [31:0]   tx_wb, rx_wb;
   logic          tx_we, rx_we, tx_busy_nc;

   assign a_int   = int'(reg_addr);
   assign tbl_off = a_int - BD_BASE;
   assign aligned = (reg_addr[1:0] == 2'b00);
   assign hit_cnt = aligned && (a_int == CNT_ADDR);
   assign hit_tbl = aligned && (a_int >= BD_BASE) && (a_int < TBL_END);
   assign cpu_idx = tbl_off[IW+2:3];
   assign cnt_we  = reg_we && hit_cnt;
   assign count_d = (reg_wdata > 32'(NUM_BD)) ? CW'(NUM_BD) : reg_wdata[CW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)      count_q <= CW'(CNT_RST);
      else if (cnt_we) count_q <= count_d;
   end

   always_comb begin
      if (hit_cnt)      reg_rdata = 32'(count_q);
      else if (hit_tbl) reg_rdata = cpu_rdata;
      else              reg_rdata = '0;
   end

   bdr_table #(.NUM_BD(NUM_BD)) u_table (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(reg_we && hit_tbl), .cpu_idx(cpu_idx), .cpu_word(reg_addr[2]),
      .cpu_wdata(reg_wdata), .cpu_rdata(cpu_rdata),
      .hw_a_we(tx_we), .hw_a_idx(tx_idx), .hw_a_stat(tx_wb),
      .hw_b_we(rx_we), .hw_b_idx(rx_idx), .hw_b_stat(rx_wb),
      .a_stat(tx_stat), .a_addr(tx_addr), .b_stat(rx_stat), .b_addr(rx_addr)
   );

   bdr_walker #(.NUM_BD(NUM_BD), .KIND(WALK_TX)) u_tx_walk (
      .clk(clk), .rst_n(rst_n), .restart_i(cnt_we),
      .lo_i('0), .hi_i(count_q - 1'b1), .active_i(count_q != '0),
      .cur_stat_i(tx_stat), .evt_i(tx_done), .res_i(tx_result), .len_i(16'h0),
      .idx_o(tx_idx), .avail_o(tx_req), .wr_en_o(tx_we), .wr_stat_o(tx_wb),
      .ok_o(ev_tx_ok), .err_o(ev_tx_err), .busy_o(tx_busy_nc)
   );

   bdr_walker #(.NUM_BD(NUM_BD), .KIND(WALK_RX)) u_rx_walk (
      .clk(clk), .rst_n(rst_n), .restart_i(cnt_we),
      .lo_i(count_q), .hi_i(CW'(NUM_BD - 1)), .active_i(count_q < CW'(NUM_BD)),
      .cur_stat_i(rx_stat), .evt_i(rx_frame), .res_i(rx_err), .len_i(rx_len),
      .idx_o(rx_idx), .avail_o(rx_buf_ok), .wr_en_o(rx_we), .wr_stat_o(rx_wb),
      .ok_o(ev_rx_ok), .err_o(ev_rx_err), .busy_o(ev_rx_busy)
   );

   assign tx_buf_addr = tx_addr;
   assign tx_len      = tx_stat[31:LEN_LSB];
   assign tx_pad      = tx_stat[PAD_BIT];
   assign tx_crc      = tx_stat[CRC_BIT];
   assign rx_buf_addr = rx_addr;

   p_done_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> tx_req);
   p_count_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(NUM_BD));
   p_tx_busy_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy_nc);
endmodule

// File: tb/bd_ring_seq_tb.sv
module bd_ring_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_req, tx_pad, tx_crc, rx_buf_ok;
   logic [31:0] tx_buf_addr, rx_buf_addr;
   logic [15:0] tx_len;
   logic        tx_done = 1'b0, rx_frame = 1'b0;
   logic [8:0]  tx_result = '0, rx_err = '0;
   logic [15:0] rx_len = '0;
   logic        ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_rx_busy;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   bd_ring_seq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
      .tx_buf_addr(tx_buf_addr), .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc),
      .tx_done(tx_done), .tx_result(tx_result), .rx_buf_ok(rx_buf_ok),
      .rx_buf_addr(rx_buf_addr), .rx_frame(rx_frame), .rx_len(rx_len), .rx_err(rx_err),
      .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err), .ev_rx_ok(ev_rx_ok),
      .ev_rx_err(ev_rx_err), .ev_rx_busy(ev_rx_busy)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_stat [128];
   logic [31:0] m_addr [128];
   int m_cnt, txi, rxi, new_cnt, widx;
   bit txav, rxav, cnt_wr;
   logic [31:0] cur_tx, cur_rx;
   bit e_tx_ok, e_tx_err, e_rx_ok, e_rx_err, e_busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) begin m_stat[i] = '0; m_addr[i] = '0; end
         m_cnt = 64; txi = 0; rxi = 64;
         {e_tx_ok, e_tx_err, e_rx_ok, e_rx_err, e_busy} = '0;
      end else begin
         txav   = (m_cnt != 0) && m_stat[txi][15];
         rxav   = (m_cnt < 128) && m_stat[rxi][15];
         cur_tx = m_stat[txi];
         cur_rx = m_stat[rxi];
         cnt_wr = 1'b0;
         {e_tx_ok, e_tx_err, e_rx_ok, e_rx_err, e_busy} = '0;
         if (reg_we && reg_addr[1:0] == 2'b00) begin
            if (reg_addr == 12'h020) begin
               cnt_wr = 1'b1;
               new_cnt = (reg_wdata > 128) ? 128 : int'(reg_wdata);
            end else if (reg_addr >= 12'h400) begin
               widx = (int'(reg_addr) - 'h400) / 8;
               if (reg_addr[2]) m_addr[widx] = reg_wdata;
               else             m_stat[widx] = reg_wdata;
            end
         end
         if (tx_done && txav) begin
            m_stat[txi] = {cur_tx[31:16], 1'b0, cur_tx[14:9], tx_result};
            e_tx_ok  = cur_tx[14] && (tx_result == 0);
            e_tx_err = cur_tx[14] && (tx_result != 0);
            txi = (cur_tx[13] || txi == m_cnt - 1) ? 0 : txi + 1;
         end
         if (rx_frame && rxav) begin
            m_stat[rxi] = {rx_len, 1'b0, cur_rx[14:9], rx_err};
            e_rx_ok  = cur_rx[14] && (rx_err == 0);
            e_rx_err = cur_rx[14] && (rx_err != 0);
            rxi = (cur_rx[13] || rxi == 127) ? m_cnt : rxi + 1;
         end
         if (rx_frame && !rxav) e_busy = 1'b1;
         if (cnt_wr) begin m_cnt = new_cnt; txi = 0; rxi = new_cnt; end
      end
   end

   // every-clock comparison of walker outputs and events (R4, R8, R9)
   bit x_txr, x_rxo, bad;
   always @(posedge clk) begin
      #5;
      if (rst_n && !done_flag) begin
         x_txr = (m_cnt != 0) && m_stat[txi][15];
         x_rxo = (m_cnt < 128) && m_stat[rxi][15];
         bad = (tx_req !== x_txr) || (rx_buf_ok !== x_rxo)
            || (x_txr && (tx_buf_addr !== m_addr[txi] || tx_len !== m_stat[txi][31:16]))
            || (x_rxo && rx_buf_addr !== m_addr[rxi])
            || ({ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_rx_busy}
                !== {e_tx_ok, e_tx_err, e_rx_ok, e_rx_err, e_busy});
         checks++;
         if (bad) begin
            errors++;
            $display("FAIL R4/R8/R9 cycle compare at %0t: act req=%b ok=%b ev=%b exp req=%b ok=%b ev=%b",
               $time, tx_req, rx_buf_ok,
               {ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_rx_busy},
               x_txr, x_rxo, {e_tx_ok, e_tx_err, e_rx_ok, e_rx_err, e_busy});
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic td, input logic [8:0] tr,
                      input logic rf, input logic [15:0] rl, input logic [8:0] re);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d;
      tx_done = td; tx_result = tr; rx_frame = rf; rx_len = rl; rx_err = re;
      @(negedge clk);
      reg_we = 1'b0; tx_done = 1'b0; rx_frame = 1'b0;
      tx_result = '0; rx_err = '0; rx_len = '0;
      #2;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0, 9'h0, 1'b0, 16'h0, 9'h0);
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #2;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic report;
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=finished");
      report();
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R1 count reset", 12'h020, 32'd64);
      rd_chk("R1 table reset", 12'h400, 32'h0);
      chk("R1 tx_req reset", {31'h0, tx_req}, 32'h0);
      rd_chk("R2 unmapped", 12'h030, 32'h0);
      rd_chk("R2 unaligned", 12'h402, 32'h0);

      wr(12'h020, 32'h200);
      rd_chk("R3 clamp", 12'h020, 32'd128);
      wr(12'h020, 32'd4);
      rd_chk("R3 count 4", 12'h020, 32'd4);

      // transmit ring
      wr(12'h404, 32'h1000_0000);
      wr(12'h400, 32'h003C_D800);
      rd_chk("R2 status word", 12'h400, 32'h003C_D800);
      rd_chk("R2 address word", 12'h404, 32'h1000_0000);
      chk("R4 tx_req", {31'h0, tx_req}, 32'h1);
      chk("R4 tx_len", {16'h0, tx_len}, 32'd60);
      chk("R4 tx_pad/crc", {30'h0, tx_pad, tx_crc}, 32'h3);
      chk("R4 tx_buf_addr", tx_buf_addr, 32'h1000_0000);
      cyc(1'b0, 12'h0, 32'h0, 1'b1, 9'h000, 1'b0, 16'h0, 9'h0);
      rd_chk("R5 tx writeback ok", 12'h400, 32'h003C_5800);
      chk("R8 tx stall", {31'h0, tx_req}, 32'h0);

      wr(12'h40C, 32'h1100_0000);
      wr(12'h408, 32'h0064_8800);
      cyc(1'b0, 12'h0, 32'h0, 1'b1, 9'h014, 1'b0, 16'h0, 9'h0);
      rd_chk("R5 R9 tx result no irq", 12'h408, 32'h0064_0814);

      wr(12'h414, 32'h1200_0000);
      wr(12'h410, 32'h0008_E000);
      cyc(1'b0, 12'h0, 32'h0, 1'b1, 9'h100, 1'b0, 16'h0, 9'h0);
      rd_chk("R5 tx underrun", 12'h410, 32'h0008_6100);
      wr(12'h400, 32'h003C_D800);
      chk("R7 tx wrap back to 0", tx_buf_addr, 32'h1000_0000);
      cyc(1'b0, 12'h0, 32'h0, 1'b1, 9'h000, 1'b0, 16'h0, 9'h0);

      // receive ring starts at index 4
      cyc(1'b0, 12'h0, 32'h0, 1'b0, 9'h0, 1'b1, 16'd64, 9'h0);
      rd_chk("R8 busy leaves table", 12'h420, 32'h0);
      wr(12'h424, 32'h2000_0000);
      wr(12'h420, 32'h0000_C000);
      chk("R6 rx_buf_ok", {31'h0, rx_buf_ok}, 32'h1);
      cyc(1'b0, 12'h0, 32'h0, 1'b0, 9'h0, 1'b1, 16'd64, 9'h0);
      rd_chk("R6 rx writeback", 12'h420, 32'h0040_4000);
      wr(12'h42C, 32'h2100_0000);
      wr(12'h428, 32'h0000_E000);
      cyc(1'b0, 12'h0, 32'h0, 1'b0, 9'h0, 1'b1, 16'd80, 9'h002);
      rd_chk("R6 rx error writeback", 12'h428, 32'h0050_6002);
      wr(12'h420, 32'h0000_C000);
      chk("R7 rx wrap back to ring start", rx_buf_addr, 32'h2000_0000);

      // R11: tx completion, rx frame and processor write in one cycle
      wr(12'h408, 32'h0020_C000);
      cyc(1'b1, 12'h408, 32'hFFFF_FFFF, 1'b1, 9'h000, 1'b1, 16'd72, 9'h0);
      rd_chk("R11 tx wb beats cpu", 12'h408, 32'h0020_4000);
      rd_chk("R11 rx wb same cycle", 12'h420, 32'h0048_4000);

      // R10: count write restarts both walkers
      wr(12'h400, 32'h003C_D800);
      chk("R10 before restart", {31'h0, tx_req}, 32'h0);
      wr(12'h020, 32'd2);
      chk("R10 tx restart at 0", tx_buf_addr, 32'h1000_0000);
      chk("R10 tx_req after restart", {31'h0, tx_req}, 32'h1);
      wr(12'h410, 32'h0000_C000);
      chk("R10 rx restart at count", rx_buf_addr, 32'h1200_0000);

      // R3 corners
      wr(12'h020, 32'h80);
      chk("R3 count 128 rx idle", {31'h0, rx_buf_ok}, 32'h0);
      cyc(1'b0, 12'h0, 32'h0, 1'b0, 9'h0, 1'b1, 16'd64, 9'h0);
      wr(12'h020, 32'h0);
      chk("R3 count 0 tx idle", {31'h0, tx_req}, 32'h0);
      repeat (3) @(negedge clk);
      report();
   end
endmodule